// File: doc/BRIEF.md
# MDIO Clause 22 Gateway Master

This block lets software run single Clause 22 management transactions to an external PHY through two 32-bit register words. A command word at byte offset 0x0 carries the PHY address, register address, opcode, the 16-bit write data (or, after a read, the returned data) and a busy flag. A configuration word at byte offset 0x4 holds the MDC period and two in-period offsets: one for driving the management data line and one for sampling it.

Software starts a transaction by writing a command word with the busy flag set, and then polls until the flag drops. While busy, the block sends the full 64-bit management frame on an open-drain line. It pulls the line low for a 0 and releases it for a 1. The block also generates the management clock. When a read completes, the 16 captured bits replace the low half of the command word. Writing a zero word cancels any transaction that is running. The pad cell, the core clock source and Clause 45 framing are not part of this block.

Top module: `mdio_gw_top`

## Requirements
- R1: Command word fields: data in bits 15:0, register address in bits 20:16, PHY address in bits 25:21, opcode in bits 27:26, start bit in bit 28 and busy in bit 30. Bits 29 and 31 always read 0. A read of offset 0x0 returns the stored fields together with the live busy flag.
- R2: A transaction starts only on a command write made while idle that has bit 30 = 1, bit 28 = 1 and an opcode of 1 (write) or 2 (read). Any other command write while idle stores its fields with busy read back as 0, and no MDC edge follows.
- R3: The line carries 64 bits per frame, MSB first, in this order: 32 ones, the pair 0 then 1, the opcode, the PHY address, the register address, the two turnaround bits, and 16 data bits. On a write the turnaround bits are 1 then 0.
- R4: On a read, the block never pulls the line from the first turnaround bit (bit 46 of the frame) through the last data bit. The 16 values sampled during data bits 48..63, first sample in bit 15, replace command bits 15:0 in the same cycle that busy clears.
- R5: MDC is low whenever no transaction is active. With period field P (configuration bits 15:8), every MDC period lasts 2*(P+1) core cycles: low for the first P+1 and high for the next P+1. The first rising edge comes P+1 cycles after the command write edge.
- R6: With output offset O (configuration bits 31:24), the value of frame bit i+1 appears on the line O+1 cycles into the MDC period of bit i. With input offset I (configuration bits 23:16), the line is sampled at cycle I of each data-bit period.
- R7: Busy reads 1 from the command write edge until exactly 64*2*(P+1) cycles later, and reads 0 from then on.
- R8: While busy, any command write other than all zeros is ignored. The stored fields, the frame on the line and the busy timing stay unchanged.
- R9: A write of 0x00000000 to the command word clears every command field and busy at the next edge. It also forces MDC low and releases the line.
- R10: Configuration fields: mode in bits 1:0, 3.3 V select in bit 2, full drive in bit 4, period in 15:8, input offset in 23:16 and output offset in 31:24. The word reads back as written. It resets to mode 1, 3.3 V select 1, full drive 1, and the default period, input offset and output offset parameters.
- R11: The pull-low output is asserted only while a transaction is sending a 0 bit. It is deasserted in reset and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Byte offset: 0x0 command, 0x4 configuration |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for the word at regAddr, combinational |
| mdc | output | 1 | Management clock to the pad |
| mdioPullLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| mdioIn | input | 1 | Resolved level of the data line |

## Verification
The checks follow each frame bit by bit on the resolved line, so a wrong slot counter or shift position shows up at the first MDC rising edge after the error. A wrong period or offset count shows up as an early or late MDC edge, or an early or late pull-low change, within one MDC period. A busy flag that clears too early or too late shows up in the poll count. A read-capture fault shows up only when busy drops, as a wrong low half of the command word. A second configuration samples after the PHY has already moved on, which exposes an input offset that is ignored.

// File: rtl/mdio_gw_pkg.sv
package mdio_gw_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_SLOT    = 46;
  localparam int DATA_SLOT  = 48;
  localparam int SLOT_W     = $clog2(FRAME_BITS);
  localparam int DIV_W      = 8;   // width of period and offset fields
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_RD = 2'd2;

  typedef struct packed {
    logic shiftOut;  // advance the line to the next frame bit
    logic sampleIn;  // capture the line into the read shifter
    logic finish;    // last cycle of the last bit period
  } ctlStrobe_t;
endpackage

// File: rtl/mdio_gw_ctrl.sv
module mdio_gw_ctrl
  import mdio_gw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              abortReq,
  input  logic [DIV_W-1:0]  period,
  input  logic [DIV_W-1:0]  inOff,
  input  logic [DIV_W-1:0]  outOff,
  output logic              active,
  output logic              mdc,
  output logic [SLOT_W-1:0] slot,
  output ctlStrobe_t        strobe
);
  localparam int CNT_W = DIV_W + 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0]  cnt, cntNxt;
  logic [SLOT_W-1:0] slotNxt;
  logic              activeNxt;
  logic [CNT_W-1:0]  lastCnt;
  logic              endOfPeriod, lastSlot;

  assign lastCnt     = {period, 1'b1};           // 2*(P+1)-1
  assign endOfPeriod = (cnt == lastCnt);
  assign lastSlot    = (slot == LAST_SLOT);

  assign strobe.shiftOut = active && (cnt == {1'b0, outOff}) && !lastSlot;
  assign strobe.sampleIn = active && (cnt == {1'b0, inOff}) &&
                           (slot >= SLOT_W'(DATA_SLOT));
  assign strobe.finish   = active && endOfPeriod && lastSlot;

  always_comb begin
    activeNxt = active;
    cntNxt    = cnt;
    slotNxt   = slot;
    if (abortReq) begin
      activeNxt = 1'b0;
      cntNxt    = '0;
      slotNxt   = '0;
    end else if (startReq) begin
      activeNxt = 1'b1;
      cntNxt    = '0;
      slotNxt   = '0;
    end else if (active) begin
      if (endOfPeriod) begin
        cntNxt = '0;
        if (lastSlot) begin
          activeNxt = 1'b0;
          slotNxt   = '0;
        end else begin
          slotNxt = slot + 1'b1;
        end
      end else begin
        cntNxt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
      slot   <= '0;
      mdc    <= 1'b0;
    end else begin
      active <= activeNxt;
      cnt    <= cntNxt;
      slot   <= slotNxt;
      mdc    <= activeNxt && (cntNxt > {1'b0, period});
    end
  end

  // R7: busy only ends naturally at the end of the final bit period
  assert_full_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) && !$past(abortReq) |->
      ($past(slot) == LAST_SLOT) && ($past(cnt) == $past(lastCnt)));

  // R5: a rising MDC edge lands exactly P+1 cycles into its period
  assert_mdc_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) && $stable(period) |-> cnt == ({1'b0, period} + 1'b1));

  // R9: an abort leaves the clock low and the engine idle
  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(abortReq) |-> !active && !mdc);
endmodule

// File: rtl/mdio_gw_datapath.sv
module mdio_gw_datapath
  import mdio_gw_pkg::*;
#(
  parameter int DEF_PERIOD = 49,
  parameter int DEF_IN_OFF = 6,
  parameter int DEF_OUT_OFF = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             busy,
  input  ctlStrobe_t       strobe,
  input  logic             mdioIn,
  output logic             startReq,
  output logic             abortReq,
  output logic [DIV_W-1:0] period,
  output logic [DIV_W-1:0] inOff,
  output logic [DIV_W-1:0] outOff,
  output logic             cmdIsRead,
  output logic             pullLow
);
  localparam logic [31:0] CFG_RESET = {DIV_W'(DEF_OUT_OFF), DIV_W'(DEF_IN_OFF),
                                       DIV_W'(DEF_PERIOD), 8'h15};

  logic [15:0] cmdData;
  logic [4:0]  cmdReg, cmdPhy;
  logic [1:0]  cmdOp;
  logic        cmdSt;
  logic [31:0] cfgWord;
  logic [FRAME_BITS-1:0] frameSh;
  logic [15:0] readSh, readNxt;
  logic        cmdWr, cfgWr, cmdTake, goBits, opLegal;
  logic [1:0]  wrOp;

  assign cmdWr    = regWrEn && (regAddr == 3'h0);
  assign cfgWr    = regWrEn && (regAddr == 3'h4);
  assign abortReq = cmdWr && (regWdata == 32'h0);
  assign cmdTake  = cmdWr && (!busy || abortReq);
  assign wrOp     = regWdata[27:26];
  assign opLegal  = (wrOp == OP_WR) || (wrOp == OP_RD);
  assign goBits   = regWdata[30] && regWdata[28];
  assign startReq = cmdTake && !busy && goBits && opLegal;

  assign period    = cfgWord[15:8];
  assign inOff     = cfgWord[23:16];
  assign outOff    = cfgWord[31:24];
  assign cmdIsRead = (cmdOp == OP_RD);
  assign pullLow   = busy && !frameSh[FRAME_BITS-1];
  assign readNxt   = strobe.sampleIn ? {readSh[14:0], mdioIn} : readSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdData <= '0;
      cmdReg  <= '0;
      cmdPhy  <= '0;
      cmdOp   <= '0;
      cmdSt   <= 1'b0;
      cfgWord <= CFG_RESET;
      frameSh <= '1;
      readSh  <= '0;
    end else begin
      if (cfgWr) cfgWord <= regWdata;
      readSh <= readNxt;
      if (cmdTake) begin
        cmdData <= regWdata[15:0];
        cmdReg  <= regWdata[20:16];
        cmdPhy  <= regWdata[25:21];
        cmdOp   <= wrOp;
        cmdSt   <= regWdata[28];
      end else if (strobe.finish && cmdIsRead) begin
        cmdData <= readNxt;
      end
      if (startReq) begin
        frameSh <= {{PRE_BITS{1'b1}}, 2'b01, wrOp, regWdata[25:21],
                    regWdata[20:16],
                    (wrOp == OP_WR) ? 2'b10 : 2'b11,
                    (wrOp == OP_WR) ? regWdata[15:0] : 16'hFFFF};
      end else if (abortReq || strobe.finish) begin
        frameSh <= '1;
      end else if (strobe.shiftOut) begin
        frameSh <= {frameSh[FRAME_BITS-2:0], 1'b1};
      end
    end
  end

  always_comb begin
    case (regAddr)
      3'h0:    regRdata = {1'b0, busy, 1'b0, cmdSt, cmdOp, cmdPhy, cmdReg, cmdData};
      3'h4:    regRdata = cfgWord;
      default: regRdata = '0;
    endcase
  end

  // R2: a frame is only launched for a legal Clause 22 command
  assert_start_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> cmdSt && ((cmdOp == OP_WR) || (cmdOp == OP_RD)));

  // R8: addressing fields cannot move while a frame is running
  assert_fields_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(cmdPhy) && $stable(cmdReg) && $stable(cmdOp));

  // R11: the line is never pulled while idle
  assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !pullLow);
endmodule

// File: rtl/mdio_gw_top.sv
module mdio_gw_top
  import mdio_gw_pkg::*;
#(
  parameter int DEF_PERIOD  = 49,
  parameter int DEF_IN_OFF  = 6,
  parameter int DEF_OUT_OFF = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        mdc,
  output logic        mdioPullLow,
  input  logic        mdioIn
);
  logic             busy, startReq, abortReq, cmdIsRead;
  logic [DIV_W-1:0] period, inOff, outOff;
  logic [SLOT_W-1:0] slot;
  ctlStrobe_t       strobe;

  mdio_gw_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .period(period), .inOff(inOff), .outOff(outOff),
    .active(busy), .mdc(mdc), .slot(slot), .strobe(strobe)
  );

  mdio_gw_datapath #(
    .DEF_PERIOD(DEF_PERIOD), .DEF_IN_OFF(DEF_IN_OFF), .DEF_OUT_OFF(DEF_OUT_OFF)
  ) uData (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .strobe(strobe),
    .mdioIn(mdioIn), .startReq(startReq), .abortReq(abortReq),
    .period(period), .inOff(inOff), .outOff(outOff),
    .cmdIsRead(cmdIsRead), .pullLow(mdioPullLow)
  );

  // R4: a read frame leaves the line to the PHY from the turnaround on
  assert_read_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy && cmdIsRead && (slot >= SLOT_W'(TA_SLOT)) |-> !mdioPullLow);
endmodule

// File: tb/tb_mdio_gw_top.sv
`timescale 1ns/1ps
module tb_mdio_gw_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'h0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        mdc, mdioPullLow, mdioIn;
  logic        phyBit = 1'b1;

  assign mdioIn = phyBit & ~mdioPullLow;   // wired-AND open-drain line

  mdio_gw_top dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc),
    .mdioPullLow(mdioPullLow), .mdioIn(mdioIn)
  );

  always #2 clk = ~clk;   // 250 MHz

  int vecCount = 0, errCount = 0;
  int cyc = 0, startCyc = 0, lastRise = 0, riseIdx = 0;
  int curP = 49, curOut = 13;
  bit frameOn = 1'b0, frameRead = 1'b0, pullSeen = 1'b0, checkPull = 1'b0;
  logic [15:0] phyVal = '0;
  logic mdcPrev = 1'b0, pullPrev = 1'b0;
  bit expBits[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    vecCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(input logic [1:0] op, input logic [4:0] phy,
                                        input logic [4:0] rg, input logic [15:0] d,
                                        input bit go);
    return {1'b0, go, 1'b0, 1'b1, op, phy, rg, d};
  endfunction

  // Monitor and PHY model, sampled at the falling clock edge
  always @(negedge clk) begin
    if (frameOn && mdc && !mdcPrev) begin
      if (riseIdx == 0)
        check(cyc - startCyc == curP + 1, "R5 first MDC rise", cyc - startCyc, curP + 1);
      else
        check(cyc - lastRise == 2 * (curP + 1), "R5 MDC period", cyc - lastRise, 2 * (curP + 1));
      lastRise = cyc;
      if (expBits.size() == 0)
        check(1'b0, "R3 extra MDC rise", riseIdx, 64);
      else begin
        bit e;
        e = expBits.pop_front();
        check(mdioIn == e, "R3 line bit", mdioIn, e);
      end
      if (frameRead && riseIdx >= 46)
        check(!mdioPullLow, "R4 released during read", mdioPullLow, 0);
      if (frameRead) begin
        int nx;
        nx = riseIdx + 1;
        if (nx == 47) phyBit = 1'b0;
        else if (nx >= 48 && nx <= 63) phyBit = phyVal[63 - nx];
        else phyBit = 1'b1;
      end
      riseIdx++;
    end
    if (frameOn && checkPull && !pullSeen && mdioPullLow && !pullPrev) begin
      pullSeen = 1'b1;
      check(cyc - startCyc == 31 * 2 * (curP + 1) + curOut + 1, "R6 output offset",
            cyc - startCyc, 31 * 2 * (curP + 1) + curOut + 1);
    end
    mdcPrev  = mdc;
    pullPrev = mdioPullLow;
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 3'h0;
    startCyc = cyc;
  endtask

  task automatic pushFrame(input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] d);
    logic [63:0] f;
    f = {32'hFFFFFFFF, 2'b01, op, phy, rg, 2'b10, d};
    expBits.delete();
    for (int i = 63; i >= 0; i--) expBits.push_back(f[i]);
  endtask

  task automatic waitIdle(output int elapsed);
    int n = 0;
    while (regRdata[30] && n < 20000) begin @(negedge clk); n++; end
    elapsed = cyc - startCyc;
  endtask

  // Driver: queue the expected line bits, launch, then check busy and readback
  task automatic runFrame(input logic [1:0] op, input logic [4:0] phy,
                          input logic [4:0] rg, input logic [15:0] d,
                          input logic [15:0] expData, input bit midWrite);
    int el;
    pushFrame(op, phy, rg, (op == 2'd2) ? phyVal : d);
    frameRead = (op == 2'd2);
    riseIdx = 0; pullSeen = 1'b0; phyBit = 1'b1; frameOn = 1'b1;
    regWrite(3'h0, mkCmd(op, phy, rg, d, 1'b1));
    check(regRdata == mkCmd(op, phy, rg, d, 1'b1), "R1 busy readback",
          regRdata, mkCmd(op, phy, rg, d, 1'b1));
    if (midWrite) begin
      int keep;
      repeat (200) @(negedge clk);
      keep = startCyc;
      regWrite(3'h0, mkCmd(2'd1, 5'd3, 5'd4, 16'h1111, 1'b1));
      startCyc = keep;
      check(regRdata == mkCmd(op, phy, rg, d, 1'b1), "R8 write ignored",
            regRdata, mkCmd(op, phy, rg, d, 1'b1));
    end
    waitIdle(el);
    check(el == 64 * 2 * (curP + 1), "R7 busy length", el, 64 * 2 * (curP + 1));
    check(regRdata == mkCmd(op, phy, rg, expData, 1'b0), "R4 final command word",
          regRdata, mkCmd(op, phy, rg, expData, 1'b0));
    check(expBits.size() == 0, "R3 all bits sent", expBits.size(), 0);
    check(!mdc && !mdioPullLow, "R11 idle after frame", {mdc, mdioPullLow}, 0);
    frameOn = 1'b0; frameRead = 1'b0; phyBit = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    int el;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset configuration, R1 command reset, R5/R11 idle pads
    check(regRdata == 32'h0, "R1 reset command", regRdata, 0);
    regAddr = 3'h4; #0;
    @(negedge clk);
    check(regRdata == 32'h0D063115, "R10 reset config", regRdata, 32'h0D063115);
    regAddr = 3'h0;
    check(!mdc, "R5 idle MDC", mdc, 0);
    check(!mdioPullLow, "R11 idle release", mdioPullLow, 0);

    regWrite(3'h4, 32'h0D060715);
    curP = 7; curOut = 13;
    regAddr = 3'h4; @(negedge clk);
    check(regRdata == 32'h0D060715, "R10 config readback", regRdata, 32'h0D060715);
    regAddr = 3'h0; @(negedge clk);

    // Write frame, with pull-low timing
    checkPull = 1'b1;
    runFrame(2'd1, 5'd5, 5'h1A, 16'hA53C, 16'hA53C, 1'b0);
    checkPull = 1'b0;

    // Read frame
    phyVal = 16'h9C61;
    runFrame(2'd2, 5'd17, 5'd2, 16'h0000, 16'h9C61, 1'b0);

    // Write while busy is ignored
    runFrame(2'd1, 5'd30, 5'd9, 16'h00FF, 16'h00FF, 1'b1);

    // R2 illegal opcode and missing start bit
    regWrite(3'h0, mkCmd(2'd3, 5'd1, 5'd1, 16'h1234, 1'b1));
    check(regRdata == mkCmd(2'd3, 5'd1, 5'd1, 16'h1234, 1'b0), "R2 bad opcode stored idle",
          regRdata, mkCmd(2'd3, 5'd1, 5'd1, 16'h1234, 1'b0));
    regWrite(3'h0, 32'h4400_0000 | 32'h0000_5678);
    repeat (20) begin
      @(negedge clk);
      if (mdc) check(1'b0, "R2 no clock without start bit", mdc, 0);
    end
    check(regRdata == 32'h0400_5678, "R2 no start without bit 28", regRdata, 32'h0400_5678);

    // R9 abort mid-frame
    frameOn = 1'b0;
    regWrite(3'h0, mkCmd(2'd1, 5'd7, 5'd7, 16'h0F0F, 1'b1));
    repeat (300) @(negedge clk);
    regWrite(3'h0, 32'h0);
    check(regRdata == 32'h0, "R9 abort clears word", regRdata, 0);
    check(!mdc && !mdioPullLow, "R9 abort pads idle", {mdc, mdioPullLow}, 0);
    repeat (40) begin
      @(negedge clk);
      if (mdc) check(1'b0, "R9 clock stays low", mdc, 0);
    end

    // Read after abort works
    phyVal = 16'h35A7;
    runFrame(2'd2, 5'd0, 5'd31, 16'h0000, 16'h35A7, 1'b0);

    // R6 input offset: sampling after the PHY has advanced shifts the data
    regWrite(3'h4, 32'h07060315);
    curP = 3; curOut = 7;
    @(negedge clk);
    phyVal = 16'hC3A5;
    runFrame(2'd2, 5'd9, 5'd12, 16'h0000, {16'hC3A5 << 1} | 16'h0001, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule